// File: doc/BRIEF.md
# Scatter Descriptor Table Builder

This block takes the memory segments of one disk transfer request and turns them into the physical region descriptor table that a bus-master DMA engine walks. Segments arrive one per handshake, each with a start address and a length. The length is in bytes, or in 512-byte sectors when the sector flag is set. A segment that begins exactly where the open region ends is folded into that region. Each closed region is then cut into chunks so that no chunk crosses a 64 KiB address boundary.

Every chunk leaves as two 32-bit words on a ready/valid output that carries a word index: the address word comes first and the count word follows. The count word of the final chunk has its top bit set as the end-of-table marker. When the request is complete, a one-cycle done pulse reports the result. A raised fail bit tells the caller to use programmed I/O for this request instead, either because the table would overflow or because the request held no bytes.

Top module: `prd_table_builder`

## Requirements
- R1: A segment whose start address equals the open region's address plus its accumulated size is merged into that region. A zero-length segment never opens a new region.
- R2: No chunk crosses a 64 KiB boundary. Each chunk's byte count is 0x10000 minus the low 16 bits of its address, reduced to the bytes left in the region.
- R3: Every chunk produces two words in order: the address word at index 2k and the count word at index 2k+1, where k is the chunk number starting at 0. A stalled word holds its value and index until it is accepted.
- R4: Bit 31 of the count word is set on the last chunk of the request and on no other chunk. Bits 30:16 of the count word are zero.
- R5: A 64 KiB chunk carries the value 0 in count bits 15:0.
- R6: At most MAX_ENTRIES-1 chunks (127 by default) are emitted. When the request needs more, it ends with done and fail set, and the words already emitted are void.
- R7: A request whose total length is zero emits no words and ends with done and fail set.
- R8: When seg_sectors is high, the segment length counts 512-byte sectors and the region grows by the length shifted left by 9.
- R9: done is a single-cycle pulse. After a successful request it rises in the cycle right after the final count word is accepted. fail is high only together with done. After an overflow, the remaining segments of the request are still accepted.
- R10: While reset is held and after it is released, prd_valid and done are low and seg_ready is high. The block then accepts a new request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment accepted this cycle when valid |
| seg_addr | input | 32 | Segment start address |
| seg_len | input | LEN_W | Segment length, in bytes or sectors |
| seg_sectors | input | 1 | Length is a 512-byte sector count |
| seg_last | input | 1 | Final segment of the request |
| prd_valid | output | 1 | Descriptor word offered |
| prd_ready | input | 1 | Descriptor word taken |
| prd_index | output | IDX_W | Word position in the table |
| prd_word | output | 32 | Address or count word |
| done | output | 1 | Request finished (pulse) |
| fail | output | 1 | Request must fall back to programmed I/O |

## Verification
Descriptor words are timed by the output handshake, not by a fixed latency. The bench therefore records every word on the falling edge before the rising edge that accepts it, and it checks the index along with the value. For a successful request, done must be seen on the falling edge that directly follows the capture of the final count word, which is exactly one cycle later. The fail and empty cases have no words to time against, so for those the bench waits a bounded number of cycles for done and then checks fail.

// File: rtl/prd_pkg.sv
package prd_pkg;
  localparam int WORD_W   = 32;
  localparam int SPAN_W   = 16;
  localparam int EOT_POS  = 31;

  typedef struct packed {
    logic [WORD_W-1:0] addr;
    logic [WORD_W-1:0] size;
    logic              is_final;
  } region_t;
endpackage

// File: rtl/prd_rst_sync.sv
module prd_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sh_q <= '0;
    else              sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_n_sync = sh_q[1];
endmodule

// File: rtl/prd_coalesce.sv
module prd_coalesce
  import prd_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int SECT_SHIFT = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seg_valid,
  output logic              seg_ready,
  input  logic [WORD_W-1:0] seg_addr,
  input  logic [LEN_W-1:0]  seg_len,
  input  logic              seg_sectors,
  input  logic              seg_last,
  output logic              rg_valid,
  input  logic              rg_ready,
  output region_t           rg
);
  logic [WORD_W-1:0] acc_addr_q, acc_addr_d;
  logic [WORD_W-1:0] acc_size_q, acc_size_d;
  logic              acc_vld_q, acc_vld_d;
  logic              acc_closed_q, acc_closed_d;
  region_t           out_q, out_d;
  logic              out_vld_q, out_vld_d;

  logic [WORD_W-1:0] seg_bytes;
  logic              seg_fire;
  logic              contig;

  assign seg_bytes = seg_sectors ? (WORD_W'(seg_len) << SECT_SHIFT) : WORD_W'(seg_len);
  assign seg_ready = !acc_closed_q && !out_vld_q;
  assign seg_fire  = seg_valid && seg_ready;
  assign contig    = (seg_addr == acc_addr_q + acc_size_q);

  always_comb begin
    acc_addr_d   = acc_addr_q;
    acc_size_d   = acc_size_q;
    acc_vld_d    = acc_vld_q;
    acc_closed_d = acc_closed_q;
    out_d        = out_q;
    out_vld_d    = out_vld_q;

    if (out_vld_q && rg_ready) out_vld_d = 1'b0;

    // close the final region once the output slot is free
    if (acc_closed_q && !out_vld_q) begin
      out_d.addr     = acc_addr_q;
      out_d.size     = acc_size_q;
      out_d.is_final = 1'b1;
      out_vld_d      = 1'b1;
      acc_vld_d      = 1'b0;
      acc_closed_d   = 1'b0;
    end

    if (seg_fire) begin
      if (!acc_vld_q || (acc_size_q == '0)) begin
        acc_addr_d = seg_addr;
        acc_size_d = seg_bytes;
      end else if ((seg_bytes == '0) || contig) begin
        acc_size_d = acc_size_q + seg_bytes;
      end else begin
        out_d.addr     = acc_addr_q;
        out_d.size     = acc_size_q;
        out_d.is_final = 1'b0;
        out_vld_d      = 1'b1;
        acc_addr_d     = seg_addr;
        acc_size_d     = seg_bytes;
      end
      acc_vld_d    = 1'b1;
      acc_closed_d = seg_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_addr_q   <= '0;
      acc_size_q   <= '0;
      acc_vld_q    <= 1'b0;
      acc_closed_q <= 1'b0;
      out_q        <= '0;
      out_vld_q    <= 1'b0;
    end else begin
      acc_addr_q   <= acc_addr_d;
      acc_size_q   <= acc_size_d;
      acc_vld_q    <= acc_vld_d;
      acc_closed_q <= acc_closed_d;
      out_q        <= out_d;
      out_vld_q    <= out_vld_d;
    end
  end

  assign rg_valid = out_vld_q;
  assign rg       = out_q;
endmodule

// File: rtl/prd_split.sv
module prd_split
  import prd_pkg::*;
#(
  parameter int MAX_ENTRIES = 128,
  parameter int IDX_W       = $clog2(2*MAX_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rg_valid,
  output logic              rg_ready,
  input  region_t           rg,
  output logic              prd_valid,
  input  logic              prd_ready,
  output logic [IDX_W-1:0]  prd_index,
  output logic [WORD_W-1:0] prd_word,
  output logic              done,
  output logic              fail
);
  localparam int CNT_W = $clog2(MAX_ENTRIES) + 1;

  typedef enum logic [1:0] {SP_IDLE, SP_ADDR, SP_CNT, SP_SKIP} sp_state_e;

  sp_state_e         st_q, st_d;
  logic [WORD_W-1:0] addr_q, addr_d;
  logic [WORD_W-1:0] rem_q, rem_d;
  logic              fin_q, fin_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              done_q, done_d;
  logic              fail_q, fail_d;

  logic [SPAN_W:0]   room;
  logic [WORD_W-1:0] chunk;
  logic              last_chunk;
  logic              table_full;
  logic              rg_fire;
  logic              eot;

  assign room       = (SPAN_W+1)'(1 << SPAN_W) - {1'b0, addr_q[SPAN_W-1:0]};
  assign chunk      = (rem_q < WORD_W'(room)) ? rem_q : WORD_W'(room);
  assign last_chunk = (rem_q == chunk);
  assign table_full = (cnt_q + 1'b1) >= CNT_W'(MAX_ENTRIES);
  assign eot        = fin_q && last_chunk;

  assign rg_ready  = (st_q == SP_IDLE) || (st_q == SP_SKIP);
  assign rg_fire   = rg_valid && rg_ready;
  assign prd_valid = ((st_q == SP_ADDR) && !table_full) || (st_q == SP_CNT);
  assign prd_index = {cnt_q[IDX_W-2:0], (st_q == SP_CNT)};
  assign prd_word  = (st_q == SP_CNT)
                   ? {eot, {(WORD_W-SPAN_W-1){1'b0}}, chunk[SPAN_W-1:0]}
                   : addr_q;

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    rem_d  = rem_q;
    fin_d  = fin_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    fail_d = 1'b0;

    unique case (st_q)
      SP_IDLE: if (rg_fire) begin
        addr_d = rg.addr;
        rem_d  = rg.size;
        fin_d  = rg.is_final;
        if (rg.size != '0) begin
          st_d = SP_ADDR;
        end else if (rg.is_final) begin
          done_d = 1'b1;
          fail_d = (cnt_q == '0);
          cnt_d  = '0;
        end
      end
      SP_ADDR: begin
        if (table_full) begin
          cnt_d = '0;
          if (fin_q) begin
            done_d = 1'b1;
            fail_d = 1'b1;
            st_d   = SP_IDLE;
          end else begin
            st_d = SP_SKIP;
          end
        end else if (prd_ready) begin
          st_d = SP_CNT;
        end
      end
      SP_CNT: if (prd_ready) begin
        cnt_d  = cnt_q + 1'b1;
        addr_d = addr_q + chunk;
        rem_d  = rem_q - chunk;
        if (!last_chunk) begin
          st_d = SP_ADDR;
        end else if (fin_q) begin
          done_d = 1'b1;
          cnt_d  = '0;
          st_d   = SP_IDLE;
        end else begin
          st_d = SP_IDLE;
        end
      end
      SP_SKIP: if (rg_fire && rg.is_final) begin
        done_d = 1'b1;
        fail_d = 1'b1;
        st_d   = SP_IDLE;
      end
      default: st_d = SP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SP_IDLE;
      addr_q <= '0;
      rem_q  <= '0;
      fin_q  <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      rem_q  <= rem_d;
      fin_q  <= fin_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      fail_q <= fail_d;
    end
  end

  assign done = done_q;
  assign fail = fail_q;
endmodule

// File: rtl/prd_table_builder.sv
module prd_table_builder #(
  parameter int LEN_W       = 16,
  parameter int MAX_ENTRIES = 128,
  parameter int SECT_SHIFT  = 9,
  parameter int IDX_W       = $clog2(2*MAX_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seg_valid,
  output logic              seg_ready,
  input  logic [31:0]       seg_addr,
  input  logic [LEN_W-1:0]  seg_len,
  input  logic              seg_sectors,
  input  logic              seg_last,
  output logic              prd_valid,
  input  logic              prd_ready,
  output logic [IDX_W-1:0]  prd_index,
  output logic [31:0]       prd_word,
  output logic              done,
  output logic              fail
);
  logic             rst_q_n;
  logic             rg_valid;
  logic             rg_ready;
  prd_pkg::region_t rg;

  prd_rst_sync u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_q_n)
  );

  prd_coalesce #(.LEN_W(LEN_W), .SECT_SHIFT(SECT_SHIFT)) u_merge (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .seg_valid   (seg_valid),
    .seg_ready   (seg_ready),
    .seg_addr    (seg_addr),
    .seg_len     (seg_len),
    .seg_sectors (seg_sectors),
    .seg_last    (seg_last),
    .rg_valid    (rg_valid),
    .rg_ready    (rg_ready),
    .rg          (rg)
  );

  prd_split #(.MAX_ENTRIES(MAX_ENTRIES), .IDX_W(IDX_W)) u_split (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .rg_valid  (rg_valid),
    .rg_ready  (rg_ready),
    .rg        (rg),
    .prd_valid (prd_valid),
    .prd_ready (prd_ready),
    .prd_index (prd_index),
    .prd_word  (prd_word),
    .done      (done),
    .fail      (fail)
  );
endmodule

// File: rtl/prd_table_builder_chk.sv
module prd_table_builder_chk #(
  parameter int MAX_ENTRIES = 128,
  parameter int IDX_W       = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             prd_valid,
  input logic             prd_ready,
  input logic [IDX_W-1:0] prd_index,
  input logic [15:0]      low16,
  input logic             eot,
  input logic             done,
  input logic             fail
);
  logic        phase_q;
  logic [15:0] cap_lo_q;
  logic [16:0] cnt_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= 1'b0;
      cap_lo_q <= '0;
    end else if (prd_valid && prd_ready) begin
      phase_q <= ~phase_q;
      if (!phase_q) cap_lo_q <= low16;
    end
  end

  assign cnt_eff = (low16 == '0) ? 17'h10000 : {1'b0, low16};

  AST_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    (prd_valid && phase_q) |-> ((18'(cap_lo_q) + 18'(cnt_eff)) <= 18'h10000)); // R2
  AST_WORD_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    prd_valid |-> (prd_index[0] == phase_q)); // R3
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (prd_valid && !prd_ready) |=> (prd_valid && $stable(prd_index) && $stable(low16) && $stable(eot))); // R3
  AST_EOT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (prd_valid && prd_ready && phase_q && eot) |=> (done && !fail && !prd_valid)); // R4
  AST_ENTRY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    prd_valid |-> (32'(prd_index) < 32'(2*(MAX_ENTRIES-1)))); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_FAIL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> done); // R9
endmodule

bind prd_table_builder prd_table_builder_chk #(.MAX_ENTRIES(MAX_ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .prd_valid (prd_valid),
  .prd_ready (prd_ready),
  .prd_index (prd_index),
  .low16     (prd_word[15:0]),
  .eot       (prd_word[31]),
  .done      (done),
  .fail      (fail)
);

// File: tb/prd_table_builder_test.sv
module prd_table_builder_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAXE       = 128;
  localparam int NVEC       = 16;

  // {addr, len, flags(bit1 sectors, bit0 last), spare}
  localparam logic [63:0] VEC [0:NVEC-1] = '{
    {32'h0000_1000, 16'h0200, 8'h01, 8'h00},  // R3 single
    {32'h0000_2000, 16'h0400, 8'h00, 8'h00},  // R1 merge
    {32'h0000_2400, 16'h0400, 8'h01, 8'h00},
    {32'h0000_3000, 16'h0100, 8'h00, 8'h00},  // R1 gap
    {32'h0000_5000, 16'h0100, 8'h01, 8'h00},
    {32'h0001_F000, 16'h3000, 8'h01, 8'h00},  // R2 split
    {32'h0004_0000, 16'h8000, 8'h00, 8'h00},  // R5 full 64K
    {32'h0004_8000, 16'h8000, 8'h01, 8'h00},
    {32'h0005_0000, 16'h0003, 8'h03, 8'h00},  // R8 sectors
    {32'h0006_0000, 16'h0000, 8'h01, 8'h00},  // R7 empty
    {32'h0000_FF00, 16'h0001, 8'h03, 8'h00},  // R8 + R2
    {32'h0000_7000, 16'h0200, 8'h00, 8'h00},  // R1 zero mid
    {32'h9999_0000, 16'h0000, 8'h00, 8'h00},
    {32'h0000_7200, 16'h0200, 8'h01, 8'h00},
    {32'h0007_FF00, 16'h0080, 8'h00, 8'h00},  // R1 + R2
    {32'h0007_FF80, 16'h0100, 8'h01, 8'h00}
  };

  logic        clk, rst_n;
  logic        seg_valid, seg_ready, seg_sectors, seg_last;
  logic [31:0] seg_addr;
  logic [15:0] seg_len;
  logic        prd_valid, prd_ready;
  logic [7:0]  prd_index;
  logic [31:0] prd_word;
  logic        done, fail;

  prd_table_builder uut (
    .clk(clk), .rst_n(rst_n),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
    .seg_len(seg_len), .seg_sectors(seg_sectors), .seg_last(seg_last),
    .prd_valid(prd_valid), .prd_ready(prd_ready), .prd_index(prd_index),
    .prd_word(prd_word), .done(done), .fail(fail)
  );

  int n_chk, n_bad;
  int cyc;
  bit bp_on;

  logic [31:0] got_w [0:511];
  logic [7:0]  got_i [0:511];
  int got_n, last_cyc;
  bit done_seen, done_fail;
  int done_cyc;

  logic [31:0] exp_w [0:511];
  int  m_cnt;
  bit  m_ovf, m_vld;
  logic [31:0] m_addr, m_size;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (prd_valid && prd_ready) begin
      if (got_n < 512) begin
        got_w[got_n] = prd_word;
        got_i[got_n] = prd_index;
      end
      got_n    = got_n + 1;
      last_cyc = cyc;
    end
    if (done) begin
      done_seen = 1'b1;
      done_fail = fail;
      done_cyc  = cyc;
    end
  end

  initial begin
    prd_ready = 1'b1;
    forever begin
      @(posedge clk);
      #2;
      prd_ready = bp_on ? ~prd_ready : 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // reference model built from the requirements
  task automatic m_emit(input logic [31:0] a_in, input logic [31:0] s_in);
    logic [31:0] a, s, room, c;
    a = a_in; s = s_in;
    while (s != 0 && !m_ovf) begin
      room = 32'h10000 - {16'h0, a[15:0]};
      c = (s < room) ? s : room;
      if (m_cnt + 1 >= MAXE) m_ovf = 1'b1;
      else begin
        exp_w[2*m_cnt]   = a;
        exp_w[2*m_cnt+1] = {16'h0, c[15:0]};
        m_cnt++;
        a = a + c;
        s = s - c;
      end
    end
  endtask

  task automatic m_seg(input logic [31:0] a, input logic [15:0] l, input bit sect, input bit lst);
    logic [31:0] b;
    b = sect ? ({16'h0, l} << 9) : {16'h0, l};
    if (!m_vld || m_size == 0) begin m_addr = a; m_size = b; end
    else if (b == 0 || a == m_addr + m_size) m_size = m_size + b;
    else begin m_emit(m_addr, m_size); m_addr = a; m_size = b; end
    m_vld = 1'b1;
    if (lst) begin
      m_emit(m_addr, m_size);
      m_vld = 1'b0;
      if (m_cnt > 0 && !m_ovf) exp_w[2*m_cnt-1][31] = 1'b1;
    end
  endtask

  task automatic begin_req();
    m_cnt = 0; m_ovf = 1'b0; m_vld = 1'b0;
    got_n = 0; done_seen = 1'b0; done_fail = 1'b0;
  endtask

  task automatic send_seg(input logic [31:0] a, input logic [15:0] l, input bit sect, input bit lst);
    m_seg(a, l, sect, lst);
    seg_addr = a; seg_len = l; seg_sectors = sect; seg_last = lst;
    seg_valid = 1'b1;
    while (!seg_ready) @(negedge clk);
    @(negedge clk);
    seg_valid = 1'b0;
  endtask

  task automatic finish_req(input string tag);
    int t;
    bit exp_fail;
    exp_fail = m_ovf || (m_cnt == 0);
    t = 0;
    while (!done_seen && t < 20000) begin @(negedge clk); t++; end
    @(negedge clk);
    chk(done_seen, {tag, " R9 done"}, 32'(done_seen), 32'd1);
    chk(done_fail == exp_fail, {tag, exp_fail ? " R6/R7 fail" : " R9 fail"}, 32'(done_fail), 32'(exp_fail));
    if (!exp_fail) begin
      chk(got_n == 2*m_cnt, {tag, " R3 word count"}, 32'(got_n), 32'(2*m_cnt));
      for (int k = 0; k < got_n && k < 2*m_cnt; k++) begin
        chk(got_w[k] == exp_w[k], {tag, " R1 R2 R4 R5 word"}, got_w[k], exp_w[k]);
        chk(got_i[k] == 8'(k), {tag, " R3 index"}, 32'(got_i[k]), 32'(k));
      end
      chk(done_cyc == last_cyc + 1, {tag, " R9 done timing"}, 32'(done_cyc), 32'(last_cyc + 1));
    end
  endtask

  initial begin
    int wd;
    wd = 0;
    forever begin
      @(negedge clk);
      wd++;
      if (wd > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=0x%08h expected=0x%08h", wd, 150000);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; cyc = 0; bp_on = 1'b0;
    got_n = 0; last_cyc = 0; done_cyc = 0; done_seen = 1'b0; done_fail = 1'b0;
    seg_valid = 1'b0; seg_addr = '0; seg_len = '0; seg_sectors = 1'b0; seg_last = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!prd_valid && !done, "R10 in reset", {30'h0, prd_valid, done}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(seg_ready && !prd_valid && !done, "R10 after reset", {29'h0, seg_ready, prd_valid, done}, 32'h4);

    // table walk
    begin_req();
    for (int v = 0; v < NVEC; v++) begin
      send_seg(VEC[v][63:32], VEC[v][31:16], VEC[v][9], VEC[v][8]);
      if (VEC[v][8]) begin
        finish_req($sformatf("vec%0d", v));
        begin_req();
      end
    end

    // output backpressure on the boundary split (R3 hold, R2)
    bp_on = 1'b1;
    begin_req();
    send_seg(32'h0001_F000, 16'h3000, 1'b0, 1'b1);
    finish_req("backpressure");
    bp_on = 1'b0;
    @(negedge clk);

    // R6: 127 chunks fit
    begin_req();
    for (int i = 0; i < MAXE - 1; i++)
      send_seg(32'h0010_0000 + 32'(8*i), 16'h0004, 1'b0, i == MAXE - 2);
    finish_req("R6 127 entries");

    // R6: 128 chunks overflow; all segments still accepted
    begin_req();
    for (int i = 0; i < MAXE; i++)
      send_seg(32'h0020_0000 + 32'(8*i), 16'h0004, 1'b0, i == MAXE - 1);
    finish_req("R6 overflow");

    // R6: overflow inside a non-final region, then more segments
    begin_req();
    for (int i = 0; i < MAXE + 2; i++)
      send_seg(32'h0030_0000 + 32'(8*i), 16'h0004, 1'b0, i == MAXE + 1);
    finish_req("R6 overflow drain");

    // R10: normal operation after a failure
    begin_req();
    send_seg(32'h0000_1000, 16'h0200, 1'b0, 1'b1);
    finish_req("R10 recovery");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule